// File: doc/BRIEF.md
# Vectored Interrupt Controller with Register Interface

This block gathers up to 32 interrupt lines and exposes them to a processor through eight 32-bit word registers, reached with a one-cycle write strobe and a one-cycle read strobe. Each line is fixed at elaboration to be either edge-sensitive or level-sensitive. Events on the lines are captured into a status register. A per-line enable register gates the status into a pending set. A single request output toward the processor asserts when anything is pending and a two-bit master control allows it.

Software finds the line to service by reading the vector register. This register gives the lowest-numbered pending line, or all-ones when nothing is pending. Software then clears the event through the acknowledge register. Enables can be replaced as a whole, or set and cleared bit by bit through two separate registers, so no read-modify-write is needed.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset the status, enable and master registers are zero, `irq_req` is low, and the vector register (word index 6, offset 0x18) reads 0xFFFFFFFF.
- R2: A line whose bit in `KIND_MASK` is 1 is edge-sensitive. A 0-to-1 change of the line sets its status bit on the clock edge that samples the new level. A line held high does not set the bit again after it is acknowledged.
- R3: A line whose bit in `KIND_MASK` is 0 is level-sensitive. Its status bit is set on every clock where the line is high, so an acknowledge given while the line is high leaves the bit set.
- R4: Writing the acknowledge register (index 3, offset 0x0C) clears each status bit whose written bit is 1 and leaves the other status bits as they are. A line event in the same cycle wins over the clear.
- R5: A write to the enable register (index 2, offset 0x08) replaces all enables. A write to set-enable (index 4, offset 0x10) sets the enables whose written bit is 1. A write to clear-enable (index 5, offset 0x14) clears the enables whose written bit is 1. Written 0 bits leave enables unchanged in both of the last two registers.
- R6: The status register reads at index 0 (offset 0x00). The pending register reads at index 1 (offset 0x04) and equals status AND enable.
- R7: When at least one line is pending, the vector register reads the lowest pending line number, zero-extended.
- R8: `irq_req` is high exactly when some line is pending and both bit 0 (master enable) and bit 1 (request-output enable) of the master register (index 7, offset 0x1C) are 1.
- R9: Reads of the acknowledge, set-enable and clear-enable registers return 0. Bits at or above `N_SRC` read as 0 in every register.
- R10: Read data appears on `rdata` on the clock edge that samples `rd_en` and holds until the next read. Writes to the status, pending and vector registers have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | One-cycle write strobe |
| rd_en | input | 1 | One-cycle read strobe |
| reg_sel | input | 3 | Word index of the register (byte offset / 4) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq_line | input | N_SRC | Interrupt input lines, synchronous to clk |
| irq_req | output | 1 | Request output toward the processor |

## Verification
The assertions assume that `wr_en` and `rd_en` are single-cycle strobes and that `irq_line` is already synchronous to `clk`. They also assume that `reg_sel` and `wdata` are stable during any cycle that carries a strobe. The bench drives every input on the falling clock edge and drops each strobe after one cycle, so every value is settled before the rising edge. The acknowledge-hold property assumes status bits only fall through an acknowledge write. The stimulus never holds the reset low in the middle of a run, so that assumption stays true.

// File: rtl/vic_pkg.sv
package vic_pkg;

   localparam int unsigned WORD_W = 32;

   typedef enum logic [2:0] {
      RI_STATUS = 3'd0,
      RI_PEND   = 3'd1,
      RI_ENABLE = 3'd2,
      RI_ACK    = 3'd3,
      RI_SETEN  = 3'd4,
      RI_CLREN  = 3'd5,
      RI_VECTOR = 3'd6,
      RI_MASTER = 3'd7
   } reg_idx_e;

endpackage

// File: rtl/vic_capture.sv
module vic_capture #(
   parameter int unsigned N_SRC = 32,
   parameter logic [31:0] KIND_MASK = 32'h0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] line_i,
   output logic [N_SRC-1:0] hit_o
);

   for (genvar g = 0; g < N_SRC; g++) begin : g_src
      if (KIND_MASK[g]) begin : g_edge
         logic prev_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev_q <= 1'b0;
            else        prev_q <= line_i[g];
         end
         assign hit_o[g] = line_i[g] & ~prev_q;
      end else begin : g_level
         assign hit_o[g] = line_i[g];
      end
   end

endmodule

// File: rtl/vic_lowest.sv
module vic_lowest #(
   parameter int unsigned N_SRC = 32,
   localparam int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
   input  logic [N_SRC-1:0] req_i,
   output logic             found_o,
   output logic [IDX_W-1:0] idx_o
);

   always_comb begin
      idx_o = '0;
      for (int i = N_SRC - 1; i >= 0; i--) begin
         if (req_i[i]) idx_o = IDX_W'(i);
      end
   end

   assign found_o = |req_i;

endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
   import vic_pkg::*;
#(
   parameter int unsigned N_SRC = 32,
   parameter logic [31:0] KIND_MASK = 32'h0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             rd_en,
   input  logic [2:0]       reg_sel,
   input  logic [31:0]      wdata,
   output logic [31:0]      rdata,
   input  logic [N_SRC-1:0] irq_line,
   output logic             irq_req
);

   localparam int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;

   if (N_SRC < 1 || N_SRC > WORD_W) begin : g_bad_count
      $error("vec_irq_ctrl: N_SRC must be 1..32");
   end
   if (N_SRC < WORD_W) begin : g_kind_chk
      if ((KIND_MASK >> N_SRC) != 32'h0) begin : g_bad_kind
         $error("vec_irq_ctrl: KIND_MASK has bits above N_SRC");
      end
   end

   logic [N_SRC-1:0] status_q, enable_q, hit, pend;
   logic [1:0]       master_q;
   logic             found;
   logic [IDX_W-1:0] low_idx;
   logic [N_SRC-1:0] wbits;
   reg_idx_e         sel;

   assign sel   = reg_idx_e'(reg_sel);
   assign wbits = wdata[N_SRC-1:0];

   vic_capture #(.N_SRC(N_SRC), .KIND_MASK(KIND_MASK)) cap_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .line_i (irq_line),
      .hit_o  (hit)
   );

   assign pend = status_q & enable_q;

   vic_lowest #(.N_SRC(N_SRC)) low_i (
      .req_i   (pend),
      .found_o (found),
      .idx_o   (low_idx)
   );

   // status: line events win over an acknowledge in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status_q <= '0;
      end else begin
         if (wr_en && sel == RI_ACK) status_q <= (status_q & ~wbits) | hit;
         else                        status_q <= status_q | hit;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         enable_q <= '0;
         master_q <= 2'b00;
      end else if (wr_en) begin
         unique case (sel)
            RI_ENABLE: enable_q <= wbits;
            RI_SETEN:  enable_q <= enable_q | wbits;
            RI_CLREN:  enable_q <= enable_q & ~wbits;
            RI_MASTER: master_q <= wdata[1:0];
            default:   ;
         endcase
      end
   end

   logic [31:0] rd_mux;
   always_comb begin
      unique case (sel)
         RI_STATUS: rd_mux = 32'(status_q);
         RI_PEND:   rd_mux = 32'(pend);
         RI_ENABLE: rd_mux = 32'(enable_q);
         RI_VECTOR: rd_mux = found ? 32'(low_idx) : 32'hFFFF_FFFF;
         RI_MASTER: rd_mux = {30'd0, master_q};
         default:   rd_mux = 32'd0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rdata <= 32'd0;
      else if (rd_en) rdata <= rd_mux;
   end

   assign irq_req = found & master_q[0] & master_q[1];

endmodule

// File: rtl/vic_chk.sv
module vic_chk
   import vic_pkg::*;
#(
   parameter int unsigned N_SRC = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic             rd_en,
   input logic [2:0]       reg_sel,
   input logic [31:0]      wdata,
   input logic [31:0]      rdata,
   input logic             irq_req,
   input logic [N_SRC-1:0] status,
   input logic [N_SRC-1:0] enable,
   input logic [1:0]       master
);

   // R8: a request implies both master bits and a pending line
   a_r8_req_gated: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> (master == 2'b11 && (status & enable) != '0));

   // R5: set-enable leaves every written-1 bit set
   a_r5_set_en: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && reg_sel == RI_SETEN) |=>
         ((enable & $past(wdata[N_SRC-1:0])) == $past(wdata[N_SRC-1:0])));

   // R5: clear-enable leaves every written-1 bit clear
   a_r5_clr_en: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && reg_sel == RI_CLREN) |=>
         ((enable & $past(wdata[N_SRC-1:0])) == '0));

   // R4: without an acknowledge write no status bit falls
   a_r4_status_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && reg_sel == RI_ACK) |=> ((status & $past(status)) == $past(status)));

   // R9: write-only registers read back as zero
   a_r9_wo_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && (reg_sel == RI_ACK || reg_sel == RI_SETEN || reg_sel == RI_CLREN))
         |=> (rdata == 32'd0));

   // R10: read data holds between read strobes
   a_r10_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rdata));

endmodule

bind vec_irq_ctrl vic_chk #(.N_SRC(N_SRC)) chk_i (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_en   (wr_en),
   .rd_en   (rd_en),
   .reg_sel (reg_sel),
   .wdata   (wdata),
   .rdata   (rdata),
   .irq_req (irq_req),
   .status  (status_q),
   .enable  (enable_q),
   .master  (master_q)
);

// File: tb/vec_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module vec_irq_ctrl_tb_top;

   localparam int unsigned N = 8;
   localparam logic [31:0] KIND = 32'h0000_00F0; // lines 4..7 edge, 0..3 level

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0, rd_en = 1'b0;
   logic [2:0]  reg_sel = 3'd0;
   logic [31:0] wdata = 32'd0;
   logic [31:0] rdata;
   logic [N-1:0] irq_line = '0;
   logic        irq_req;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   vec_irq_ctrl #(.N_SRC(N), .KIND_MASK(KIND)) dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
      .reg_sel(reg_sel), .wdata(wdata), .rdata(rdata),
      .irq_line(irq_line), .irq_req(irq_req)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] s, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; reg_sel = s; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [2:0] s, output logic [31:0] d);
      @(negedge clk);
      rd_en = 1'b1; reg_sel = s;
      @(negedge clk);
      rd_en = 1'b0;
      d = rdata;
   endtask

   function automatic logic [31:0] lowest(input logic [N-1:0] p);
      logic [31:0] r = 32'hFFFF_FFFF;
      for (int i = N - 1; i >= 0; i--) if (p[i]) r = i;
      return r;
   endfunction

   initial begin : watchdog
      #(5.0 * 150000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: got hung expected finish");
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

   initial begin : stim
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(3'd0, v); chk("R1 status", v, 0);
      rd(3'd2, v); chk("R1 enable", v, 0);
      rd(3'd7, v); chk("R1 master", v, 0);
      rd(3'd6, v); chk("R1 vector", v, 32'hFFFF_FFFF);
      chk("R1 irq_req", 32'(irq_req), 0);

      // R9 write-only reads and unused bits
      wr(3'd4, 32'hFFFF_FFFF);
      rd(3'd2, v); chk("R9 enable upper bits", v, 32'h0000_00FF);
      rd(3'd3, v); chk("R9 ack reads 0", v, 0);
      rd(3'd4, v); chk("R9 seten reads 0", v, 0);
      rd(3'd5, v); chk("R9 clren reads 0", v, 0);
      wr(3'd7, 32'hFFFF_FFFF);
      rd(3'd7, v); chk("R9 master upper bits", v, 3);

      // R2/R3/R4/R7 per line
      for (int i = 0; i < N; i++) begin
         wr(3'd3, 32'hFF);
         @(negedge clk); irq_line[i] = 1'b1;
         @(negedge clk);
         rd(3'd0, v); chk("R2 R3 status set", v, 32'(1) << i);
         rd(3'd6, v); chk("R7 vector single", v, i);
         chk("R8 irq_req single", 32'(irq_req), 1);
         wr(3'd3, 32'(1) << i);
         rd(3'd0, v);
         if (KIND[i]) chk("R2 edge held no reset", v, 0);
         else         chk("R3 level re-sets", v, 32'(1) << i);
         @(negedge clk); irq_line[i] = 1'b0;
         wr(3'd3, 32'(1) << i);
         rd(3'd0, v); chk("R4 ack clears", v, 0);
      end

      // R10 writes to read-only registers ignored
      wr(3'd0, 32'hFF); wr(3'd1, 32'hFF); wr(3'd6, 32'h0);
      rd(3'd0, v); chk("R10 status write ignored", v, 0);
      rd(3'd6, v); chk("R10 vector write ignored", v, 32'hFFFF_FFFF);

      // latch all lines: levels held high, edges pulsed
      @(negedge clk); irq_line = 8'hFF;
      @(negedge clk); irq_line = 8'h0F;
      rd(3'd0, v); chk("R2 R3 all latched", v, 32'hFF);

      // R5/R6/R7/R8 sweep of all enable patterns
      for (int e = 0; e < 256; e++) begin
         wr(3'd2, e);
         rd(3'd1, v); chk("R6 pending", v, e);
         rd(3'd6, v); chk("R7 vector lowest", v, lowest(e[N-1:0]));
         chk("R8 irq_req", 32'(irq_req), (e != 0) ? 1 : 0);
      end

      // R8 master combinations
      wr(3'd2, 32'h10);
      for (int m = 0; m < 4; m++) begin
         wr(3'd7, m);
         chk("R8 master gate", 32'(irq_req), (m == 3) ? 1 : 0);
      end

      // R5 set / clear bitwise
      wr(3'd2, 32'h0F);
      wr(3'd4, 32'h30);
      rd(3'd2, v); chk("R5 set-enable", v, 32'h3F);
      wr(3'd5, 32'h05);
      rd(3'd2, v); chk("R5 clear-enable", v, 32'h3A);
      wr(3'd2, 32'h0);
      rd(3'd2, v); chk("R5 enable replace", v, 0);

      // R4 partial ack, edges only (levels still high)
      wr(3'd3, 32'hA0);
      rd(3'd0, v); chk("R4 partial ack", v, 32'h5F);

      // R10 rdata holds after read
      rd(3'd0, v);
      repeat (3) @(negedge clk);
      chk("R10 rdata hold", rdata, 32'h5F);

      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

endmodule